// File: doc/BRIEF.md
# Hold-Up Converter Mode Sequencer

This block chooses the operating mode of a bidirectional converter that keeps a storage capacitor charged while the DC bus is healthy and feeds the critical load from that capacitor when the bus sags. It takes digitised samples of the bus voltage and the capacitor voltage, qualified by a sample-valid strobe. It compares them against five programmable thresholds and moves between four modes: off-line, charge, stand-by and discharge.

In charge mode the charge current loop is enabled until the capacitor is full. Stand-by then lets the capacitor self-discharge until it sags below a lower threshold, and charging resumes, which gives a hysteresis band on the capacitor voltage. A bus sag pre-empts both charge and stand-by: the load is cut off from the bus and the discharge loop regulates it from the capacitor. Discharge ends only when the capacitor is exhausted. On that exit the bus switch recloses and the discharge regulator gets a one-cycle command to clear its integrator.

The thresholds are 12-bit ADC codes written through a small register port. The reset values correspond to a 25 mV code step: bus nominal 1120 (28 V), bus minimum 880 (22 V), capacitor full 3120 (78 V), capacitor recharge 2920 (73 V) and capacitor empty 480 (12 V).

Top module: `holdup_mode_seq`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (off-line), `chg_en` and `dis_en` are 0, `bus_sw_closed` is 1 and `integ_clr` is 0.
- R2: The mode codes are 00 off-line, 01 charge, 10 stand-by and 11 discharge. `chg_en` is 1 only in mode 01 and `dis_en` is 1 only in mode 11, so at most one of them is high. `bus_sw_closed` is 0 only in mode 11.
- R3: The mode changes only at a clock edge where `smp_valid` is 1, and each valid sample causes at most one transition.
- R4: In off-line mode, a valid sample with `bus_code` strictly greater than the bus-nominal threshold moves the mode to charge. A bus value equal to that threshold keeps the mode at off-line.
- R5: In charge mode, a valid sample with `cap_code` greater than or equal to the capacitor-full threshold moves the mode to stand-by, provided R7 does not apply.
- R6: In stand-by mode, a valid sample with `cap_code` strictly below the recharge threshold moves the mode back to charge, provided R7 does not apply. A value equal to that threshold keeps the mode at stand-by.
- R7: In charge or stand-by mode, a valid sample with `bus_code` strictly below the bus-minimum threshold moves the mode to discharge. This takes priority over R5 and R6. A bus value equal to the minimum does not trigger discharge.
- R8: In discharge mode, a valid sample with `cap_code` strictly below the capacitor-empty threshold moves the mode to off-line. A value equal to that threshold, or a recovered bus on its own, keeps the mode at discharge.
- R9: `integ_clr` is high for exactly the one cycle that follows the clock edge at which the mode leaves discharge, and is low at all other times.
- R10: Threshold registers are written when `cfg_we` is 1, at address 0 bus nominal, 1 bus minimum, 2 capacitor full, 3 capacitor recharge and 4 capacitor empty. A written value governs every sample taken after the write edge. The reset values are 1120, 880, 3120, 2920 and 480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Threshold register write enable |
| cfg_addr | input | 3 | Threshold register address |
| cfg_wdata | input | 12 | Threshold value in ADC codes |
| smp_valid | input | 1 | Sample-valid strobe |
| bus_code | input | 12 | Bus voltage sample |
| cap_code | input | 12 | Storage capacitor voltage sample |
| mode_o | output | 2 | Current mode code |
| chg_en | output | 1 | Charge current loop enable |
| dis_en | output | 1 | Discharge current loop enable |
| bus_sw_closed | output | 1 | Bus-to-load switch closed |
| integ_clr | output | 1 | Discharge regulator integrator clear pulse |

## Verification
The sequence of samples walks the full cycle off-line, charge, stand-by, recharge, discharge and back to off-line. Each threshold is hit at its exact code and one code past it, which distinguishes strict comparisons from inclusive ones. Samples that meet two conditions at once, such as a sagging bus together with a full or drooping capacitor, show whether discharge really wins. A recovered bus during discharge shows that only capacitor exhaustion ends that mode. Samples with the strobe low, and samples taken after a threshold rewrite, separate gating and configuration faults from faults in the transition logic.

// File: rtl/hold_pkg.sv
package hold_pkg;

  typedef enum logic [1:0] {
    MODE_OFFL = 2'b00,
    MODE_CHRG = 2'b01,
    MODE_STBY = 2'b10,
    MODE_DISC = 2'b11
  } mode_t;

  localparam int NUM_THR    = 5;
  localparam int THR_BUS_NOM = 0;
  localparam int THR_BUS_MIN = 1;
  localparam int THR_CAP_MAX = 2;
  localparam int THR_CAP_NOM = 3;
  localparam int THR_CAP_MIN = 4;

  typedef struct packed {
    logic bus_ok;     // bus above nominal
    logic bus_sag;    // bus below minimum
    logic cap_full;   // capacitor at or above full level
    logic cap_droop;  // capacitor below recharge level
    logic cap_empty;  // capacitor below empty level
  } cmp_flags_t;

endpackage

// File: rtl/hold_thr_regs.sv
module hold_thr_regs #(
  parameter int W      = 12,
  parameter int NUM    = 5,
  parameter int ADDR_W = 3,
  parameter logic [NUM*W-1:0] RST_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [NUM*W-1:0]  thr_vec
);

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_vec[g*W +: W] <= RST_VEC[g*W +: W];
      end else if (hit) begin
        thr_vec[g*W +: W] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/hold_cmp.sv
module hold_cmp
  import hold_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0]         bus_code,
  input  logic [W-1:0]         cap_code,
  input  logic [NUM_THR*W-1:0] thr_vec,
  output cmp_flags_t           flags
);

  logic [W-1:0] t_bus_nom, t_bus_min, t_cap_max, t_cap_nom, t_cap_min;

  assign t_bus_nom = thr_vec[THR_BUS_NOM*W +: W];
  assign t_bus_min = thr_vec[THR_BUS_MIN*W +: W];
  assign t_cap_max = thr_vec[THR_CAP_MAX*W +: W];
  assign t_cap_nom = thr_vec[THR_CAP_NOM*W +: W];
  assign t_cap_min = thr_vec[THR_CAP_MIN*W +: W];

  always_comb begin
    flags.bus_ok    = bus_code >  t_bus_nom;
    flags.bus_sag   = bus_code <  t_bus_min;
    flags.cap_full  = cap_code >= t_cap_max;
    flags.cap_droop = cap_code <  t_cap_nom;
    flags.cap_empty = cap_code <  t_cap_min;
  end

endmodule

// File: rtl/hold_mode_fsm.sv
module hold_mode_fsm
  import hold_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  input  cmp_flags_t flags,
  output mode_t      mode_q,
  output logic       integ_clr_q
);

  mode_t mode_d;
  logic  leave_disc;

  always_comb begin
    mode_d = mode_q;
    if (smp_valid) begin
      unique case (mode_q)
        MODE_OFFL: if (flags.bus_ok)    mode_d = MODE_CHRG;
        MODE_CHRG: begin
          if (flags.bus_sag)            mode_d = MODE_DISC;
          else if (flags.cap_full)      mode_d = MODE_STBY;
        end
        MODE_STBY: begin
          if (flags.bus_sag)            mode_d = MODE_DISC;
          else if (flags.cap_droop)     mode_d = MODE_CHRG;
        end
        MODE_DISC: if (flags.cap_empty) mode_d = MODE_OFFL;
        default:                        mode_d = MODE_OFFL;
      endcase
    end
  end

  assign leave_disc = (mode_q == MODE_DISC) && (mode_d != MODE_DISC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_OFFL;
      integ_clr_q <= 1'b0;
    end else begin
      if (smp_valid) begin
        mode_q <= mode_d;
      end
      integ_clr_q <= leave_disc;
    end
  end

endmodule

// File: rtl/holdup_mode_seq.sv
module holdup_mode_seq
  import hold_pkg::*;
#(
  parameter int W               = 12,
  parameter int ADDR_W          = 3,
  parameter logic [W-1:0] RST_BUS_NOM = 12'd1120,
  parameter logic [W-1:0] RST_BUS_MIN = 12'd880,
  parameter logic [W-1:0] RST_CAP_MAX = 12'd3120,
  parameter logic [W-1:0] RST_CAP_NOM = 12'd2920,
  parameter logic [W-1:0] RST_CAP_MIN = 12'd480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [W-1:0]      cfg_wdata,
  input  logic              smp_valid,
  input  logic [W-1:0]      bus_code,
  input  logic [W-1:0]      cap_code,
  output logic [1:0]        mode_o,
  output logic              chg_en,
  output logic              dis_en,
  output logic              bus_sw_closed,
  output logic              integ_clr
);

  localparam logic [NUM_THR*W-1:0] RST_VEC =
    {RST_CAP_MIN, RST_CAP_NOM, RST_CAP_MAX, RST_BUS_MIN, RST_BUS_NOM};

  logic [NUM_THR*W-1:0] thr_vec;
  cmp_flags_t           flags;
  mode_t                mode_q;

  hold_thr_regs #(
    .W(W), .NUM(NUM_THR), .ADDR_W(ADDR_W), .RST_VEC(RST_VEC)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .thr_vec(thr_vec)
  );

  hold_cmp #(.W(W)) i_cmp (
    .bus_code(bus_code), .cap_code(cap_code), .thr_vec(thr_vec), .flags(flags)
  );

  hold_mode_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .flags(flags),
    .mode_q(mode_q), .integ_clr_q(integ_clr)
  );

  always_comb begin
    mode_o        = mode_q;
    chg_en        = (mode_q == MODE_CHRG);
    dis_en        = (mode_q == MODE_DISC);
    bus_sw_closed = (mode_q != MODE_DISC);
  end

endmodule

// File: rtl/hold_mode_seq_chk.sv
module hold_mode_seq_chk
  import hold_pkg::*;
#(
  parameter int W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic [W-1:0]         bus_code,
  input logic [W-1:0]         cap_code,
  input logic [NUM_THR*W-1:0] thr_vec,
  input logic [1:0]           mode_o,
  input logic                 chg_en,
  input logic                 dis_en,
  input logic                 bus_sw_closed,
  input logic                 integ_clr
);

  logic [W-1:0] c_bus_nom, c_bus_min, c_cap_max, c_cap_nom, c_cap_min;
  assign c_bus_nom = thr_vec[THR_BUS_NOM*W +: W];
  assign c_bus_min = thr_vec[THR_BUS_MIN*W +: W];
  assign c_cap_max = thr_vec[THR_CAP_MAX*W +: W];
  assign c_cap_nom = thr_vec[THR_CAP_NOM*W +: W];
  assign c_cap_min = thr_vec[THR_CAP_MIN*W +: W];

  AST_ONE_LOOP_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chg_en, dis_en})); // R2

  AST_SW_OPEN_IN_DISC: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en |-> !bus_sw_closed); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(mode_o)); // R3

  AST_OFFL_TO_CHRG: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_o == 2'b00 && bus_code > c_bus_nom) |=> mode_o == 2'b01); // R4

  AST_CHRG_TO_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_o == 2'b01 && bus_code >= c_bus_min && cap_code >= c_cap_max)
    |=> mode_o == 2'b10); // R5

  AST_STBY_RECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_o == 2'b10 && bus_code >= c_bus_min && cap_code < c_cap_nom)
    |=> mode_o == 2'b01); // R6

  AST_SAG_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (mode_o == 2'b01 || mode_o == 2'b10) && bus_code < c_bus_min)
    |=> mode_o == 2'b11); // R7

  AST_DISC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_o == 2'b11 && cap_code < c_cap_min)
    |=> (mode_o == 2'b00 && integ_clr)); // R9

  AST_DISC_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && !(smp_valid && cap_code < c_cap_min))
    |=> mode_o == 2'b11); // R8

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    integ_clr |=> !integ_clr); // R9

endmodule

bind holdup_mode_seq hold_mode_seq_chk #(.W(W)) i_chk (.*);

// File: tb/test_holdup_mode_seq.sv
module test_holdup_mode_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic        smp_valid;
  logic [11:0] bus_code;
  logic [11:0] cap_code;
  logic [1:0]  mode_o;
  logic        chg_en, dis_en, bus_sw_closed, integ_clr;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  holdup_mode_seq i_holdup_mode_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .bus_code(bus_code),
    .cap_code(cap_code), .mode_o(mode_o), .chg_en(chg_en), .dis_en(dis_en),
    .bus_sw_closed(bus_sw_closed), .integ_clr(integ_clr)
  );

  // {bus, cap, expected mode} with reset thresholds 1120/880/3120/2920/480
  localparam int NV = 16;
  localparam logic [25:0] VEC [NV] = '{
    {12'd1000, 12'd0,    2'b00},  // R4 bus below nominal
    {12'd1120, 12'd0,    2'b00},  // R4 bus equal to nominal
    {12'd1121, 12'd0,    2'b01},  // R4 one code above
    {12'd1200, 12'd3119, 2'b01},  // R5 one code short of full
    {12'd1200, 12'd3120, 2'b10},  // R5 exactly full
    {12'd1200, 12'd2920, 2'b10},  // R6 equal to recharge level
    {12'd880,  12'd3000, 2'b10},  // R7 bus equal to minimum
    {12'd1200, 12'd2919, 2'b01},  // R6 droop
    {12'd800,  12'd3500, 2'b11},  // R7 sag beats full
    {12'd1200, 12'd1000, 2'b11},  // R8 bus recovered, stays
    {12'd1200, 12'd480,  2'b11},  // R8 equal to empty
    {12'd1200, 12'd479,  2'b00},  // R8 empty
    {12'd1200, 12'd0,    2'b01},  // R4 recharge from off-line
    {12'd1200, 12'd3200, 2'b10},  // R5
    {12'd879,  12'd2000, 2'b11},  // R7 sag beats droop
    {12'd100,  12'd100,  2'b00}   // R8
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_outputs(input logic [1:0] m);
    check("R2 chg_en", int'(chg_en), int'(m == 2'b01));
    check("R2 dis_en", int'(dis_en), int'(m == 2'b11));
    check("R2 bus_sw_closed", int'(bus_sw_closed), int'(m != 2'b11));
  endtask

  task automatic sample(input logic [11:0] b, input logic [11:0] c);
    @(negedge clk);
    bus_code  = b;
    cap_code  = c;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic write_thr(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset_state();
    check("R1 mode", int'(mode_o), 0);
    check("R1 chg_en", int'(chg_en), 0);
    check("R1 dis_en", int'(dis_en), 0);
    check("R1 bus_sw_closed", int'(bus_sw_closed), 1);
    check("R1 integ_clr", int'(integ_clr), 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] prev_m;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    smp_valid = 1'b0; bus_code = '0; cap_code = '0;
    do_reset();
    check_reset_state();

    prev_m = 2'b00;
    for (int i = 0; i < NV; i++) begin
      logic [1:0] em;
      em = VEC[i][1:0];
      sample(VEC[i][25:14], VEC[i][13:2]);
      check($sformatf("R4-R8 vector %0d mode", i), int'(mode_o), int'(em));
      check_outputs(em);
      check("R9 integ_clr pulse", int'(integ_clr),
            int'(prev_m == 2'b11 && em != 2'b11));
      @(negedge clk);
      check("R9 integ_clr single cycle", int'(integ_clr), 0);
      prev_m = em;
    end

    // R3: no strobe, no move
    @(negedge clk);
    bus_code = 12'd2000; cap_code = 12'd0;
    repeat (3) @(negedge clk);
    check("R3 strobe low holds off-line", int'(mode_o), 0);

    // R10: raise bus nominal to 2000
    write_thr(3'd0, 12'd2000);
    sample(12'd1500, 12'd0);
    check("R10 new bus nominal not exceeded", int'(mode_o), 0);
    sample(12'd2001, 12'd0);
    check("R10 new bus nominal exceeded", int'(mode_o), 1);
    // R10: lower capacitor full to 1000
    write_thr(3'd2, 12'd1000);
    sample(12'd2100, 12'd1000);
    check("R10 new capacitor full", int'(mode_o), 2);

    // R1: reset in stand-by restores defaults and off-line
    do_reset();
    check_reset_state();
    sample(12'd1121, 12'd0);
    check("R10 reset value of bus nominal", int'(mode_o), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule